// File: doc/BRIEF.md
# Descriptor-Driven Three-Dimensional Address Generator

This block executes one transfer descriptor stored in a bank of eight-word parameter slots. Slot 0 is the active slot. The descriptor describes a nest of three counts:

- A: bytes per array.
- B: arrays per frame.
- C: frames.

For every array the block issues one transfer request that carries a source address, a destination address and a byte count. A downstream data mover consumes these requests. Each accepted sync event advances the nest. In array-sync mode an event moves one array. In frame-sync mode an event moves a whole frame.

Addresses step by signed 16-bit B and C strides, unless that side is set to constant (FIFO) addressing. When the final array of the final frame has been handed off, one of three things happens:

- The descriptor in the linked slot is copied into slot 0.
- If the link field holds the no-link value, slot 0 is cleared to a null descriptor.
- If the static option is set, slot 0 is left as it stands.

Software loads slots through a plain word-write port while the block is idle. The sync-event input is a valid/ready pair: `evt_ready` is high only when no event is in progress, and an event is taken on a cycle where `evt_valid` and `evt_ready` are both high. The request output is also valid/ready. Once `req_valid` is raised, the request and its fields hold until `req_ready` is seen high at a clock edge. The completion, link and null-error outputs are single-cycle pulses with no handshake.

Top module: `desc_addr_walker`

## Requirements
- R1: A slot is written one 32-bit word at a time through `cfg_*`. The word index selects the field:
  - 0: options.
  - 1: source address.
  - 2: counts, with A in bits 15:0 and B in bits 31:16.
  - 3: destination address.
  - 4: B strides, source in 15:0 and destination in 31:16.
  - 5: link in 15:0 and B reload in 31:16.
  - 6: C strides, source in 15:0 and destination in 31:16.
  - 7: C count in 15:0.
- R2: After reset, `req_valid`, `done_pulse`, `link_pulse` and `null_err` are 0 and `evt_ready` is 1.
- R3: With option bit 2 at 0 (array sync), each event issues one request of A bytes. If B > 1, both addresses then advance by their sign-extended B stride and B decrements. Otherwise they advance by their C stride, B takes the reload value and C decrements.
- R4: With option bit 2 at 1 (frame sync), each event issues B requests. These start at the frame address and step by the B stride. Afterwards the frame address advances by the C stride and C decrements, while B is kept.
- R5: Option bit 0 (source) or bit 1 (destination) at 1 holds that address constant across all steps.
- R6: While `req_valid` is high and `req_ready` low, the request fields hold stable. `evt_ready` stays low from event acceptance until the final request of that event is taken.
- R7: When C reaches 0, `done_pulse` rises for one cycle, in the cycle after the final handshake, carrying option bits 17:12 on `done_code`. This happens only if option bit 20 is 1.
- R8: On completion with option bit 3 at 0 and a link value other than 0xFFFF, the slot selected by the low link bits is copied into slot 0 and `link_pulse` rises for one cycle.
- R9: On completion with link 0xFFFF and option bit 3 at 0, slot 0 is cleared. Any event taken while A, B or C of slot 0 is 0 issues no request and raises `null_err` for one cycle, in the next cycle.
- R10: With option bit 3 at 1, completion performs no reload and no clear. Slot 0 keeps its final counts (C = 0), so the next event raises `null_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Slot word write strobe |
| cfg_slot | input | SLOT_W | Slot number for the write |
| cfg_word | input | 3 | Word index within the slot |
| cfg_data | input | 32 | Write data |
| evt_valid | input | 1 | Sync event offered |
| evt_ready | output | 1 | Event can be accepted (idle) |
| req_valid | output | 1 | Transfer request valid |
| req_ready | input | 1 | Data mover takes the request |
| req_src | output | 32 | Source byte address |
| req_dst | output | 32 | Destination byte address |
| req_bytes | output | 16 | Bytes in this array (A count) |
| done_pulse | output | 1 | Descriptor completed, interrupt enabled |
| done_code | output | 6 | Completion code from the options word |
| link_pulse | output | 1 | Slot 0 was reloaded from its link |
| null_err | output | 1 | Event hit a null descriptor |

## Verification
The first descriptor is an array-sync walk with a negative source C stride, run across two frames. It separates B stepping from C stepping, B reload and sign extension, and it then links to a frame-sync descriptor. That second descriptor has a constant source and a negative destination C stride, so it tells frame stepping apart from array stepping and shows the constant mode suppressing a non-zero stride. Its no-link completion is followed by an event that must hit the cleared slot. A static frame-sync descriptor runs under pseudo-random back-pressure: it shows held request fields, a completion code with no reload, and a null error on the spent slot.

// File: rtl/dw_pkg.sv
package dw_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned SLOT_WRDS = 8;

  // word positions inside a slot
  localparam int unsigned W_OPT  = 0;
  localparam int unsigned W_SRC  = 1;
  localparam int unsigned W_CNT  = 2;
  localparam int unsigned W_DST  = 3;
  localparam int unsigned W_BIDX = 4;
  localparam int unsigned W_LNK  = 5;
  localparam int unsigned W_CIDX = 6;
  localparam int unsigned W_CCNT = 7;

  // option bits
  localparam int unsigned OB_SRC_FIX = 0;
  localparam int unsigned OB_DST_FIX = 1;
  localparam int unsigned OB_FSYNC   = 2;
  localparam int unsigned OB_STATIC  = 3;
  localparam int unsigned OB_CODE_LO = 12;
  localparam int unsigned OB_CODE_HI = 17;
  localparam int unsigned OB_INTEN   = 20;

  localparam logic [15:0] NO_LINK = 16'hFFFF;

  // word 0 in the low 32 bits
  typedef struct packed {
    logic [WORD_W-1:0] ccnt;
    logic [WORD_W-1:0] cidx;
    logic [WORD_W-1:0] lnk;
    logic [WORD_W-1:0] bidx;
    logic [WORD_W-1:0] dst;
    logic [WORD_W-1:0] cnt;
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] opt;
  } desc_t;
endpackage

// File: rtl/dw_addr_step.sv
module dw_addr_step (
  input  logic [31:0] base,
  input  logic [15:0] idx,
  input  logic        fixed,
  output logic [31:0] nxt
);
  always_comb begin
    if (fixed) nxt = base;
    else       nxt = base + {{16{idx[15]}}, idx};
  end
endmodule

// File: rtl/dw_slot_store.sv
module dw_slot_store
  import dw_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SLOT_W-1:0]   cfg_slot,
  input  logic [2:0]          cfg_word,
  input  logic [WORD_W-1:0]   cfg_data,
  input  logic                upd_en,
  input  logic [WORD_W-1:0]   upd_src,
  input  logic [WORD_W-1:0]   upd_dst,
  input  logic [WORD_W-1:0]   upd_cnt,
  input  logic [WORD_W-1:0]   upd_ccnt,
  input  logic                reload_en,
  input  logic [SLOT_W-1:0]   reload_slot,
  input  logic                clear_en,
  output desc_t               act
);
  logic [WORD_W-1:0] mem [NUM_SLOTS][SLOT_WRDS];

  always_comb begin
    act = '0;
    for (int w = 0; w < SLOT_WRDS; w++) act[w*WORD_W +: WORD_W] = mem[0][w];
  end

  // engine operations are placed last so they win over a same-cycle write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        for (int w = 0; w < SLOT_WRDS; w++) mem[s][w] <= '0;
    end else begin
      if (cfg_we) mem[cfg_slot][cfg_word] <= cfg_data;
      if (upd_en) begin
        mem[0][W_SRC]  <= upd_src;
        mem[0][W_DST]  <= upd_dst;
        mem[0][W_CNT]  <= upd_cnt;
        mem[0][W_CCNT] <= upd_ccnt;
      end else if (reload_en) begin
        for (int w = 0; w < SLOT_WRDS; w++) mem[0][w] <= mem[reload_slot][w];
      end else if (clear_en) begin
        for (int w = 0; w < SLOT_WRDS; w++)
          mem[0][w] <= (w == W_LNK) ? {16'h0000, NO_LINK} : '0;
      end
    end
  end

  assert_one_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_en, reload_en, clear_en}));

  assert_clear_null_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_en |=> (act.ccnt[15:0] == 16'h0 && act.lnk[15:0] == NO_LINK));
endmodule

// File: rtl/dw_nest_engine.sv
module dw_nest_engine
  import dw_pkg::*;
#(
  parameter int unsigned SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  desc_t             act,
  input  logic              evt_valid,
  output logic              evt_ready,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [31:0]       req_src,
  output logic [31:0]       req_dst,
  output logic [15:0]       req_bytes,
  output logic              upd_en,
  output logic [31:0]       upd_src,
  output logic [31:0]       upd_dst,
  output logic [31:0]       upd_cnt,
  output logic [31:0]       upd_ccnt,
  output logic              reload_en,
  output logic [SLOT_W-1:0] reload_slot,
  output logic              clear_en,
  output logic              done_pulse,
  output logic [5:0]        done_code,
  output logic              link_pulse,
  output logic              null_err
);
  typedef enum logic {S_IDLE, S_ISSUE} st_t;
  st_t st_q;

  logic [15:0] a_cnt, b_cnt, c_cnt, lnk, b_rld, arr_left_q;
  logic        fsync, is_null, evt_fire, hs, fin, frame_end, desc_done, stat;
  logic [15:0] nxt_b, nxt_c;
  logic [1:0][31:0] cur_q, cur_nxt, wb_nxt, slot_addr;
  logic [1:0][15:0] bi, ci;

  assign a_cnt = act.cnt[15:0];
  assign b_cnt = act.cnt[31:16];
  assign c_cnt = act.ccnt[15:0];
  assign lnk   = act.lnk[15:0];
  assign b_rld = act.lnk[31:16];
  assign fsync = act.opt[OB_FSYNC];
  assign stat  = act.opt[OB_STATIC];
  assign is_null = (a_cnt == 0) || (b_cnt == 0) || (c_cnt == 0);

  assign slot_addr = {act.dst, act.src};
  assign bi = act.bidx;
  assign ci = act.cidx;

  assign evt_ready = (st_q == S_IDLE);
  assign evt_fire  = evt_valid && evt_ready;
  assign req_valid = (st_q == S_ISSUE);
  assign req_src   = cur_q[0];
  assign req_dst   = cur_q[1];
  assign req_bytes = a_cnt;
  assign hs  = req_valid && req_ready;
  assign fin = hs && (arr_left_q == 16'd1);

  assign frame_end = fsync || (b_cnt <= 16'd1);
  assign nxt_b     = frame_end ? (fsync ? b_cnt : b_rld) : (b_cnt - 16'd1);
  assign nxt_c     = frame_end ? (c_cnt - 16'd1) : c_cnt;
  assign desc_done = frame_end && (c_cnt == 16'd1);

  // per-side steppers: one for the in-frame walk, one for slot write-back
  for (genvar g = 0; g < 2; g++) begin : g_side
    dw_addr_step u_cur (
      .base(cur_q[g]), .idx(bi[g]), .fixed(act.opt[g]), .nxt(cur_nxt[g]));
    dw_addr_step u_wb (
      .base(slot_addr[g]), .idx(frame_end ? ci[g] : bi[g]),
      .fixed(act.opt[g]), .nxt(wb_nxt[g]));
  end

  assign upd_src     = wb_nxt[0];
  assign upd_dst     = wb_nxt[1];
  assign upd_cnt     = {nxt_b, a_cnt};
  assign upd_ccnt    = {act.ccnt[31:16], nxt_c};
  assign reload_slot = lnk[SLOT_W-1:0];
  assign upd_en      = fin && !(desc_done && !stat);
  assign reload_en   = fin && desc_done && !stat && (lnk != NO_LINK);
  assign clear_en    = fin && desc_done && !stat && (lnk == NO_LINK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      cur_q      <= '0;
      arr_left_q <= '0;
      done_pulse <= 1'b0;
      done_code  <= '0;
      link_pulse <= 1'b0;
      null_err   <= 1'b0;
    end else begin
      done_pulse <= fin && desc_done && act.opt[OB_INTEN];
      link_pulse <= reload_en;
      null_err   <= evt_fire && is_null;
      if (fin) done_code <= act.opt[OB_CODE_HI:OB_CODE_LO];
      case (st_q)
        S_IDLE: if (evt_fire && !is_null) begin
          st_q       <= S_ISSUE;
          cur_q      <= slot_addr;
          arr_left_q <= fsync ? b_cnt : 16'd1;
        end
        S_ISSUE: if (hs) begin
          if (arr_left_q == 16'd1) st_q <= S_IDLE;
          else begin
            cur_q      <= cur_nxt;
            arr_left_q <= arr_left_q - 16'd1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_src)
      && $stable(req_dst) && $stable(req_bytes)));

  assert_done_after_hs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(req_valid && req_ready));

  assert_null_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    null_err |-> (!req_valid && $past(evt_valid && evt_ready)));

  assert_bytes_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_bytes != 16'h0));
endmodule

// File: rtl/desc_addr_walker.sv
module desc_addr_walker
  import dw_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [2:0]        cfg_word,
  input  logic [31:0]       cfg_data,
  input  logic              evt_valid,
  output logic              evt_ready,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [31:0]       req_src,
  output logic [31:0]       req_dst,
  output logic [15:0]       req_bytes,
  output logic              done_pulse,
  output logic [5:0]        done_code,
  output logic              link_pulse,
  output logic              null_err
);
  desc_t             act;
  logic              upd_en, reload_en, clear_en;
  logic [31:0]       upd_src, upd_dst, upd_cnt, upd_ccnt;
  logic [SLOT_W-1:0] reload_slot;

  dw_slot_store #(.NUM_SLOTS(NUM_SLOTS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_word(cfg_word), .cfg_data(cfg_data),
    .upd_en(upd_en), .upd_src(upd_src), .upd_dst(upd_dst),
    .upd_cnt(upd_cnt), .upd_ccnt(upd_ccnt),
    .reload_en(reload_en), .reload_slot(reload_slot), .clear_en(clear_en),
    .act(act));

  dw_nest_engine #(.SLOT_W(SLOT_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .act(act),
    .evt_valid(evt_valid), .evt_ready(evt_ready),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_bytes(req_bytes),
    .upd_en(upd_en), .upd_src(upd_src), .upd_dst(upd_dst),
    .upd_cnt(upd_cnt), .upd_ccnt(upd_ccnt),
    .reload_en(reload_en), .reload_slot(reload_slot), .clear_en(clear_en),
    .done_pulse(done_pulse), .done_code(done_code),
    .link_pulse(link_pulse), .null_err(null_err));
endmodule

// File: tb/desc_addr_walker_tb_top.sv
module desc_addr_walker_tb_top;
  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_slot;
  logic [2:0]  cfg_word;
  logic [31:0] cfg_data;
  logic        evt_valid;
  logic        evt_ready;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_src, req_dst;
  logic [15:0] req_bytes;
  logic        done_pulse, link_pulse, null_err;
  logic [5:0]  done_code;

  always #2 clk = ~clk;

  desc_addr_walker #(.NUM_SLOTS(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_word(cfg_word), .cfg_data(cfg_data), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_bytes(req_bytes),
    .done_pulse(done_pulse), .done_code(done_code),
    .link_pulse(link_pulse), .null_err(null_err));

  typedef struct {
    logic [31:0] s;
    logic [31:0] d;
    logic [15:0] n;
  } exp_t;

  exp_t        q[$];
  logic [31:0] bm [NS][8];
  int          checks = 0;
  int          errors = 0;
  int          got_done = 0, got_link = 0, got_null = 0;
  int          exp_done = 0, exp_link = 0, exp_null = 0;
  logic [5:0]  got_code = '0, exp_code = '0;
  string       tag = "R3";
  logic        bp_en = 1'b0;
  logic        finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act_v, exp_v);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic wr(input int slot, input int word, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = slot[2:0]; cfg_word = word[2:0]; cfg_data = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    bm[slot][word] = v;
  endtask

  task automatic load(input int slot, input logic [31:0] w0, w1, w2, w3,
                      w4, w5, w6, w7);
    wr(slot, 0, w0); wr(slot, 1, w1); wr(slot, 2, w2); wr(slot, 3, w3);
    wr(slot, 4, w4); wr(slot, 5, w5); wr(slot, 6, w6); wr(slot, 7, w7);
  endtask

  // reference model of one event, written from R3..R10
  task automatic model_event();
    logic [31:0] opt, s, d, cs, cd;
    logic [15:0] a, b, c, lk;
    exp_t e;
    opt = bm[0][0];
    a = bm[0][2][15:0]; b = bm[0][2][31:16]; c = bm[0][7][15:0];
    lk = bm[0][5][15:0];
    if (a == 0 || b == 0 || c == 0) begin
      exp_null++;
      return;
    end
    s = bm[0][1]; d = bm[0][3];
    if (opt[2]) begin
      cs = s; cd = d;
      for (int i = 0; i < int'(b); i++) begin
        e.s = cs; e.d = cd; e.n = a; q.push_back(e);
        if (!opt[0]) cs = cs + sx(bm[0][4][15:0]);
        if (!opt[1]) cd = cd + sx(bm[0][4][31:16]);
      end
      if (!opt[0]) s = s + sx(bm[0][6][15:0]);
      if (!opt[1]) d = d + sx(bm[0][6][31:16]);
      c = c - 1;
    end else begin
      e.s = s; e.d = d; e.n = a; q.push_back(e);
      if (b > 1) begin
        if (!opt[0]) s = s + sx(bm[0][4][15:0]);
        if (!opt[1]) d = d + sx(bm[0][4][31:16]);
        b = b - 1;
      end else begin
        if (!opt[0]) s = s + sx(bm[0][6][15:0]);
        if (!opt[1]) d = d + sx(bm[0][6][31:16]);
        b = bm[0][5][31:16];
        c = c - 1;
      end
    end
    bm[0][1] = s; bm[0][3] = d;
    bm[0][2] = {b, a}; bm[0][7] = {bm[0][7][31:16], c};
    if (c == 0) begin
      if (opt[20]) begin exp_done++; exp_code = opt[17:12]; end
      if (!opt[3]) begin
        if (lk == 16'hFFFF) begin
          for (int w = 0; w < 8; w++) bm[0][w] = (w == 5) ? 32'h0000FFFF : 32'h0;
        end else begin
          exp_link++;
          for (int w = 0; w < 8; w++) bm[0][w] = bm[lk[2:0]][w];
        end
      end
    end
  endtask

  task automatic run_evt();
    model_event();
    @(negedge clk);
    while (!evt_ready) @(negedge clk);
    evt_valid = 1'b1;
    @(posedge clk); #1;
    evt_valid = 1'b0;
    @(negedge clk);
    while (!(evt_ready && q.size() == 0)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_counts(input string req);
    check(got_done == exp_done, "R7", "done count", got_done, exp_done);
    check(got_code == exp_code, "R7", "done code", {26'h0, got_code}, {26'h0, exp_code});
    check(got_link == exp_link, req, "link count", got_link, exp_link);
    check(got_null == exp_null, "R9", "null count", got_null, exp_null);
    check(q.size() == 0, req, "pending requests", q.size(), 0);
  endtask

  // monitor: scoreboard pop, pulse counting, hold check
  logic        p_valid = 1'b0, p_ready = 1'b0;
  logic [31:0] p_src = '0, p_dst = '0;
  logic [15:0] p_n = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_valid && !p_ready)
        check(req_valid && req_src == p_src && req_dst == p_dst && req_bytes == p_n,
              "R6", "request held", req_src, p_src);
      if (req_valid)
        check(!evt_ready, "R6", "evt_ready while busy", {31'h0, evt_ready}, 32'h0);
      if (req_valid && req_ready) begin
        if (q.size() == 0) begin
          check(1'b0, tag, "unexpected request", req_src, 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(req_src == e.s, tag, "source", req_src, e.s);
          check(req_dst == e.d, tag, "destination", req_dst, e.d);
          check(req_bytes == e.n, tag, "bytes", {16'h0, req_bytes}, {16'h0, e.n});
        end
      end
      if (done_pulse) begin got_done++; got_code = done_code; end
      if (link_pulse) got_link++;
      if (null_err) got_null++;
      p_valid = req_valid; p_ready = req_ready;
      p_src = req_src; p_dst = req_dst; p_n = req_bytes;
    end
  end

  initial begin
    #(4 * 50000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    lf = 8'h5A;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < 8; w++) bm[s][w] = 32'h0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_slot = '0; cfg_word = '0; cfg_data = '0;
    evt_valid = 1'b0; req_ready = 1'b1;
    fork
      forever begin
        @(posedge clk); #1;
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        req_ready = bp_en ? lf[0] : 1'b1;
      end
    join_none
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(req_valid == 1'b0, "R2", "req_valid", {31'h0, req_valid}, 32'h0);
    check(evt_ready == 1'b1, "R2", "evt_ready", {31'h0, evt_ready}, 32'h1);
    check(done_pulse == 1'b0, "R2", "done_pulse", {31'h0, done_pulse}, 32'h0);
    check(link_pulse == 1'b0, "R2", "link_pulse", {31'h0, link_pulse}, 32'h0);
    check(null_err == 1'b0, "R2", "null_err", {31'h0, null_err}, 32'h0);

    // R1 R3 R7 R8: array sync, two frames of three arrays, links to slot 2
    load(2, 32'h0000_0005, 32'h0000_3000, 32'h0002_0002, 32'h0000_4000,
         32'h0004_0010, 32'h0000_FFFF, 32'hFFF8_0040, 32'h0000_0002);
    load(0, 32'h0010_5000, 32'h0000_1000, 32'h0003_0004, 32'h0000_2000,
         32'h0010_0008, 32'h0003_0002, 32'h0020_FF9C, 32'h0000_0002);
    tag = "R1_R3";
    for (int i = 0; i < 6; i++) run_evt();
    check_counts("R8");

    // R4 R5 R9: linked frame-sync descriptor with constant source, then null
    tag = "R4_R5";
    for (int i = 0; i < 2; i++) run_evt();
    check_counts("R9");
    tag = "R9";
    run_evt();
    check_counts("R9");

    // R10 R6: static frame sync, constant destination, back-pressure
    load(3, 32'h0000_0000, 32'h0000_AAAA, 32'h0001_0001, 32'h0000_BBBB,
         32'h0, 32'h0000_FFFF, 32'h0, 32'h0000_0001);
    load(0, 32'h0012_A00E, 32'h0000_8000, 32'h0003_0010, 32'h0000_9000,
         32'h0000_FFFC, 32'h0001_0003, 32'h0, 32'h0000_0001);
    bp_en = 1'b1;
    tag = "R10_R6";
    run_evt();
    check_counts("R10");
    tag = "R10";
    run_evt();
    check_counts("R10");
    bp_en = 1'b0;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule